// File: doc/BRIEF.md
# Multi-Core Signature Diagnosis Automaton

The block gathers one pass/fail signature bit from each core's cache self-test and decides, with a one-dimensional cellular automaton, whether the whole system is healthy and which core is at fault. The automaton has one cell per core, numbered 1 to N from the left. Each cell's update rule is chosen by its core's signature. A failing signature forces the cell to one. A passing signature gives the cell the OR of its own value and its left neighbour's value. The left neighbour of cell 1 is a constant zero. The automaton starts from all zeros and takes N steps. A one planted by a failing core therefore spreads rightwards until it reaches cell N. The settled state reads as zeros up to the lowest-numbered failing core and as ones from that core onwards.

Cell N alone gives the go/no-go decision. When it is set, a binary search over the settled cells finds where the run of ones begins. The search probes cell N/2 first and halves the bracket on each probe. It reports the 1-based index of the lowest-numbered failing core in log2 N probes. A self-test mode checks the automaton itself. In this mode every cell uses the spreading rule and the signatures are ignored. The seed is a single one in cell 1, so a sound automaton ends all ones. The controller has five states. ST_IDLE waits after reset. ST_STEP runs the N automaton steps. ST_EVAL inspects cell N. ST_SEEK runs the bisection. ST_HOLD presents the results.

The transitions are as follows. ST_IDLE goes to ST_STEP on an accepted start. ST_STEP goes to ST_EVAL after the N-th step. ST_EVAL goes to ST_HOLD in self-test mode or when cell N is zero, and to ST_SEEK otherwise. ST_SEEK goes to ST_HOLD once the bracket has closed. ST_HOLD goes to ST_STEP on an accepted start.

Top module: `core_fault_locator`

## Requirements
- R1: After a start pulse, a cell whose core signature is 1 becomes 1 at every automaton step. A cell whose signature is 0 takes the OR of itself and its left neighbour, and the left neighbour of cell 1 is a constant 0. Core k (1-based) drives bit k-1 of `sig_in`.
- R2: The signatures and the mode are captured on the clock edge that accepts start. Changes on `sig_in` or `self_test` after that edge do not alter the result of the run.
- R3: In normal mode, after the N steps `sys_fail` equals the value of cell N. With every signature 0, `done` rises with `sys_fail` = 0 and `fault_idx` = 0, and the search is skipped.
- R4: With exactly one failing core k, the result is `sys_fail` = 1 and `fault_idx` = k, for every k from 1 to N, including both ends.
- R5: With several failing cores, `fault_idx` equals the lowest failing core number.
- R6: The bisection first probes cell N/2 and uses at most log2 N probes. `done` is seen high no later than N + log2 N + 3 clock cycles after the edge that accepted start.
- R7: In self-test mode the signatures are ignored. The automaton is seeded with a one in cell 1 and uses the spreading rule in every cell. The run ends with `sys_fail` equal to the inverse of cell N, which is 0 on sound logic, and with `fault_idx` = 0.
- R8: `done`, `sys_fail` and `fault_idx` hold their values until the next start. The edge that accepts start clears `done`.
- R9: A start pulse that arrives while a run is in progress (ST_STEP, ST_EVAL or ST_SEEK) is ignored.
- R10: After reset, `done`, `sys_fail` and `fault_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run; accepted only in ST_IDLE or ST_HOLD |
| self_test | input | 1 | Selects self-test mode for the run being started |
| sig_in | input | N | Per-core signatures; bit k-1 belongs to core k, and 1 means the core failed |
| done | output | 1 | Result valid; held until the next accepted start |
| sys_fail | output | 1 | 1 when any core failed (normal mode) or when the automaton failed its self-test |
| fault_idx | output | $clog2(N)+1 | 1-based index of the lowest failing core; 0 when no core failed |

## Verification
Two things can meet in the same clock edge. One is the capture of a fresh start request. The other is the automaton stepping through an earlier run. The bench provokes this by pulsing start mid-way through ST_STEP while flipping `sig_in` to a different failing core in that same cycle. It judges the outcome by requiring the first run's fault index, and a latency counted from the first start. A second overlap occurs in ST_HOLD, where a start must clear `done` on the very edge that begins the new run. The bench samples `done` one cycle after the start pulse to check this.

// File: rtl/core_diag_pkg.sv
package core_diag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_EVAL,
        ST_SEEK,
        ST_HOLD
    } diag_state_e;

endpackage

// File: rtl/fl_cell.sv
module fl_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic seed_bit,
    input  logic advance,
    input  logic force_one,
    input  logic left_in,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load) begin
            q <= seed_bit;
        end else if (advance) begin
            q <= force_one | left_in | q;
        end
    end

endmodule

// File: rtl/fl_automaton.sv
module fl_automaton #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] seed,
    input  logic [N-1:0] rules,
    input  logic         advance,
    output logic [N-1:0] cells
);

    logic [N-1:0] left_w;

    for (genvar j = 0; j < N; j++) begin : g_cell
        if (j == 0) begin : g_edge
            assign left_w[j] = 1'b0;
        end else begin : g_inner
            assign left_w[j] = cells[j-1];
        end

        fl_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .seed_bit  (seed[j]),
            .advance   (advance),
            .force_one (rules[j]),
            .left_in   (left_w[j]),
            .q         (cells[j])
        );
    end

    AST_FORCED_CELL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> ((cells & $past(rules)) == $past(rules))); // R1

    AST_CELLS_NEVER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> ((cells & $past(cells)) == $past(cells))); // R1

    AST_NULL_LEFT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !rules[0] && !cells[0]) |=> !cells[0]); // R1

endmodule

// File: rtl/fl_bisect.sv
module fl_bisect #(
    parameter int N     = 16,
    parameter int LOGN  = $clog2(N),
    parameter int IDX_W = $clog2(N) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             probe_en,
    input  logic [N-1:0]     cells,
    output logic             found,
    output logic [IDX_W-1:0] result
);

    logic [IDX_W-1:0] lo_q;
    logic [IDX_W-1:0] hi_q;
    logic [IDX_W-1:0] probe_cnt_q;
    logic [IDX_W:0]   sum_w;
    logic [IDX_W-1:0] mid_w;
    logic [LOGN-1:0]  slot_w;
    logic             probe_bit;

    assign sum_w     = {1'b0, lo_q} + {1'b0, hi_q};
    assign mid_w     = sum_w[IDX_W:1];
    assign slot_w    = LOGN'(mid_w - IDX_W'(1));
    assign probe_bit = cells[slot_w];
    assign found     = (lo_q == hi_q);
    assign result    = lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q        <= IDX_W'(1);
            hi_q        <= IDX_W'(N);
            probe_cnt_q <= '0;
        end else if (init) begin
            lo_q        <= IDX_W'(1);
            hi_q        <= IDX_W'(N);
            probe_cnt_q <= '0;
        end else if (probe_en && !found) begin
            probe_cnt_q <= probe_cnt_q + IDX_W'(1);
            if (probe_bit) begin
                hi_q <= mid_w;
            end else begin
                lo_q <= mid_w + IDX_W'(1);
            end
        end
    end

    AST_PROBE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        probe_cnt_q <= IDX_W'(LOGN)); // R6

    AST_BRACKET_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        lo_q <= hi_q); // R6

    AST_FIRST_PROBE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (mid_w == IDX_W'(N / 2))); // R6

endmodule

// File: rtl/core_fault_locator.sv
module core_fault_locator #(
    parameter int N = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     self_test,
    input  logic [N-1:0]             sig_in,
    output logic                     done,
    output logic                     sys_fail,
    output logic [$clog2(N):0]       fault_idx
);

    import core_diag_pkg::*;

    localparam int LOGN  = $clog2(N);
    localparam int IDX_W = LOGN + 1;
    localparam logic [N-1:0] SEED_TEST = {{(N-1){1'b0}}, 1'b1};

    diag_state_e      state_q, state_d;
    logic [LOGN-1:0]  step_cnt_q;
    logic [N-1:0]     rule_q;
    logic             mode_q;
    logic             accept;
    logic [N-1:0]     seed_w;
    logic [N-1:0]     cells_w;
    logic             last_cell;
    logic             seek_found;
    logic [IDX_W-1:0] seek_result;

    assign accept    = start && ((state_q == ST_IDLE) || (state_q == ST_HOLD));
    assign seed_w    = self_test ? SEED_TEST : '0;
    assign last_cell = cells_w[N-1];

    fl_automaton #(.N(N)) u_ca (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .seed    (seed_w),
        .rules   (rule_q),
        .advance (state_q == ST_STEP),
        .cells   (cells_w)
    );

    fl_bisect #(.N(N), .LOGN(LOGN), .IDX_W(IDX_W)) u_seek (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (state_q == ST_EVAL),
        .probe_en (state_q == ST_SEEK),
        .cells    (cells_w),
        .found    (seek_found),
        .result   (seek_result)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_STEP;
            ST_STEP: if (step_cnt_q == LOGN'(N - 1)) state_d = ST_EVAL;
            ST_EVAL: begin
                if (mode_q || !last_cell) state_d = ST_HOLD;
                else                      state_d = ST_SEEK;
            end
            ST_SEEK: if (seek_found) state_d = ST_HOLD;
            ST_HOLD: if (accept) state_d = ST_STEP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt_q <= '0;
            rule_q     <= '0;
            mode_q     <= 1'b0;
        end else if (accept) begin
            step_cnt_q <= '0;
            rule_q     <= self_test ? '0 : sig_in;
            mode_q     <= self_test;
        end else if (state_q == ST_STEP) begin
            step_cnt_q <= step_cnt_q + LOGN'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            sys_fail  <= 1'b0;
            fault_idx <= '0;
        end else if (accept) begin
            done      <= 1'b0;
            sys_fail  <= 1'b0;
            fault_idx <= '0;
        end else begin
            unique case (state_q)
                ST_EVAL: begin
                    if (mode_q) begin
                        done     <= 1'b1;
                        sys_fail <= ~last_cell;
                    end else if (!last_cell) begin
                        done     <= 1'b1;
                    end
                end
                ST_SEEK: begin
                    if (seek_found) begin
                        done      <= 1'b1;
                        sys_fail  <= 1'b1;
                        fault_idx <= seek_result;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done); // R8

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(sys_fail) && $stable(fault_idx))); // R8

    AST_PASS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sys_fail) |-> (fault_idx == '0)); // R3

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sys_fail && !mode_q) |-> ((fault_idx >= IDX_W'(1)) && (fault_idx <= IDX_W'(N)))); // R4

    AST_SELFTEST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q) |-> (!sys_fail && (fault_idx == '0))); // R7

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STEP) && start && (step_cnt_q != LOGN'(N - 1)))
        |=> ((state_q == ST_STEP) && (step_cnt_q == $past(step_cnt_q) + LOGN'(1)))); // R9

endmodule

// File: tb/sim_core_fault_locator.sv
`timescale 1ns/1ps
module sim_core_fault_locator;

    localparam int N     = 16;
    localparam int IDX_W = 5;
    localparam int BOUND = N + 4 + 3;
    localparam int NV    = 10;

    localparam logic [N-1:0] V_SIG [NV] = '{
        16'h0000, 16'h0001, 16'h8000, 16'h0010, 16'h0080,
        16'h0100, 16'h0804, 16'hFFFF, 16'h2400, 16'h0002
    };
    localparam int V_FAIL [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    localparam int V_IDX  [NV] = '{0, 1, 16, 5, 8, 9, 3, 1, 11, 2};
    localparam string V_REQ [NV] = '{"R3", "R4", "R4", "R4", "R4",
                                     "R4", "R5", "R5", "R5", "R1"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             self_test = 1'b0;
    logic [N-1:0]     sig_in = '0;
    logic             done;
    logic             sys_fail;
    logic [IDX_W-1:0] fault_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    core_fault_locator #(.N(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .self_test (self_test),
        .sig_in    (sig_in),
        .done      (done),
        .sys_fail  (sys_fail),
        .fault_idx (fault_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [N-1:0] s, input logic mode);
        @(negedge clk);
        sig_in    = s;
        self_test = mode;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    // lat counts negedges after the accepting edge until done is seen
    task automatic wait_done(input int already, output int lat);
        lat = already;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [IDX_W-1:0] kept;

        repeat (3) @(negedge clk);
        check("R10 done", int'(done), 0);
        check("R10 sys_fail", int'(sys_fail), 0);
        check("R10 fault_idx", int'(fault_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 done after release", int'(done), 0);

        for (int v = 0; v < NV; v++) begin
            pulse_start(V_SIG[v], 1'b0);
            check("R8 done cleared by start", int'(done), 0);
            wait_done(1, lat);
            check("R6 latency bound", int'(lat <= BOUND), 1);
            check({V_REQ[v], " sys_fail"}, int'(sys_fail), V_FAIL[v]);
            check({V_REQ[v], " fault_idx"}, int'(fault_idx), V_IDX[v]);
        end

        // R7 self-test with every signature failing
        pulse_start(16'hFFFF, 1'b1);
        wait_done(1, lat);
        check("R7 done", int'(done), 1);
        check("R7 sys_fail", int'(sys_fail), 0);
        check("R7 fault_idx", int'(fault_idx), 0);

        // R2 signatures and mode change right after capture
        pulse_start(16'h0000, 1'b0);
        sig_in    = 16'hFFFF;
        self_test = 1'b1;
        wait_done(1, lat);
        check("R2 sys_fail", int'(sys_fail), 0);
        check("R2 fault_idx", int'(fault_idx), 0);
        self_test = 1'b0;

        // R9 start during stepping, with different signatures in that cycle
        pulse_start(16'h0010, 1'b0);
        repeat (4) @(negedge clk);
        sig_in = 16'h0001;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        wait_done(6, lat);
        check("R9 latency from first start", int'(lat <= BOUND), 1);
        check("R9 fault_idx", int'(fault_idx), 5);
        check("R9 sys_fail", int'(sys_fail), 1);

        // R8 hold then restart
        kept = fault_idx;
        sig_in = 16'h0040;
        repeat (20) @(negedge clk);
        check("R8 done held", int'(done), 1);
        check("R8 fault_idx held", int'(fault_idx), int'(kept));
        pulse_start(16'h0040, 1'b0);
        check("R8 done cleared", int'(done), 0);
        check("R8 fault_idx cleared", int'(fault_idx), 0);
        wait_done(1, lat);
        check("R4 core 7", int'(fault_idx), 7);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule